// File: doc/BRIEF.md
# Clock Source Selection Controller

This block decides which of three system clock sources is in use: the main oscillator, a PLL-multiplied clock, or a slow subclock. Two level-sensitive control inputs state the software's wish. `want_fast_i` chooses the oscillator family (main or PLL) over the subclock. `want_direct_i` chooses the plain main clock over the PLL. Two status outputs report the source actually in use. The code is 11 for main, 10 for PLL and 01 for subclock, written as {`stat_hi_o`, `stat_nopll_o`}.

A source change never happens on the control edge alone. Each change waits for a single-cycle qualifying strobe:
- Moving from main to the subclock waits for a subclock edge.
- Moving from the subclock back to the oscillator family waits for the end of the oscillator stabilization wait. The block requests the start of that wait itself.
- Any move out of, or into, the PLL waits for a PLL/main synchronization point.

When several control changes are pending, the controller takes the one transition that leads to the final state. No intermediate status becomes visible.

`rst_n` is the asynchronous power-on reset and leaves the block on the main clock. `soft_rst_i` is a synchronous system reset. On the subclock it sends the controller straight into the stabilization wait, and from the PLL it returns to the main clock. The clock multiplexer, glitch-free gating, the oscillators and the PLL are outside this block. All pins are plain control and status signals with no handshake.

Top module: `clksrc_sel`

## Requirements
- R1: After power-on reset the status is 11 (main), and `stab_start_o` and `stat_chg_o` are 0.
- R2: On main with `want_fast_i`=0, the status stays 11 until a `sub_edge_i` strobe. It becomes 01 at the clock edge that samples the strobe. Code 00 never appears.
- R3: On the subclock with `want_fast_i`=1, the controller enters the stabilization wait. `stab_start_o` is high for exactly the first cycle of the wait, and the status stays 01 throughout the wait.
- R4: A `stab_done_i` strobe in the wait with `want_fast_i`=1 gives status 11 if `want_direct_i`=1, or 10 if `want_direct_i`=0.
- R5: On the PLL with `want_fast_i`=0, the status changes only at a `sync_pt_i` strobe. At that strobe it goes from 10 to 01 in one step, and `sub_edge_i` is ignored.
- R6: On main with `want_fast_i`=1 and `want_direct_i`=0, a `sync_pt_i` strobe moves the status to 10. On the PLL with both inputs at 1, a `sync_pt_i` strobe moves it to 11. Without that strobe the status holds.
- R7: A strobe outside its own state has no effect on any output: `stab_done_i` and `sync_pt_i` on the subclock, and `sync_pt_i` on main while `want_fast_i`=0.
- R8: On main with both control inputs at 0, the controller goes directly to the subclock at `sub_edge_i` and never shows 10.
- R9: `soft_rst_i` on the subclock enters the wait, pulsing `stab_start_o` with status 01. `soft_rst_i` on the PLL returns to status 11 at the next edge.
- R10: `stat_chg_o` is 1 in exactly those cycles whose status differs from the previous cycle's status.
- R11: A `stab_done_i` strobe in the wait with `want_fast_i`=0 returns to the subclock. The status stays 01 and `stat_chg_o` stays 0. Setting `want_fast_i` again re-enters the wait with a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst_i | input | 1 | Synchronous system reset strobe |
| want_fast_i | input | 1 | 1: oscillator family requested, 0: subclock requested |
| want_direct_i | input | 1 | 1: plain main clock requested, 0: PLL requested |
| sub_edge_i | input | 1 | Subclock edge detected strobe |
| stab_done_i | input | 1 | Oscillator stabilization wait finished strobe |
| sync_pt_i | input | 1 | PLL/main synchronization point strobe |
| stat_hi_o | output | 1 | Status: 1 when on main or PLL |
| stat_nopll_o | output | 1 | Status: 0 when on the PLL |
| stab_start_o | output | 1 | One-cycle request to start the stabilization timer |
| stat_chg_o | output | 1 | One-cycle pulse when the status code changes |

## Verification
Every output is registered, so each result is due one rising edge after the edge that samples its stimulus. This holds for the new status code, the change pulse and the stabilization start request alike. The bench changes inputs just after a falling edge and compares at the next falling edge, which is exactly one rising edge later. Holding and ignoring are checked over several such cycles before the qualifying strobe arrives. The one-cycle outputs are checked again one edge later to confirm that they have dropped.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  typedef enum logic [1:0] {
    CS_MAIN = 2'd0,
    CS_PLL  = 2'd1,
    CS_SUB  = 2'd2,
    CS_WAIT = 2'd3
  } cs_state_e;

  typedef struct packed {
    logic hi;     // 1: main or PLL
    logic nopll;  // 0: PLL
  } cs_stat_t;

  localparam cs_stat_t STAT_MAIN = '{hi: 1'b1, nopll: 1'b1};
  localparam cs_stat_t STAT_PLL  = '{hi: 1'b1, nopll: 1'b0};
  localparam cs_stat_t STAT_SUB  = '{hi: 1'b0, nopll: 1'b1};

  // The wait state keeps reporting the subclock until the switch completes.
  function automatic cs_stat_t stat_of(cs_state_e s);
    case (s)
      CS_MAIN: return STAT_MAIN;
      CS_PLL:  return STAT_PLL;
      default: return STAT_SUB;
    endcase
  endfunction

endpackage

// File: rtl/clksrc_next.sv
module clksrc_next
  import clksrc_pkg::*;
(
  input  cs_state_e cur_i,
  input  logic      soft_rst_i,
  input  logic      want_fast_i,
  input  logic      want_direct_i,
  input  logic      sub_edge_i,
  input  logic      stab_done_i,
  input  logic      sync_pt_i,
  output cs_state_e nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      CS_MAIN: begin
        if (soft_rst_i)           nxt_o = CS_MAIN;
        else if (!want_fast_i) begin
          // subclock request outranks a pending PLL request
          if (sub_edge_i)         nxt_o = CS_SUB;
        end else if (!want_direct_i && sync_pt_i)
                                  nxt_o = CS_PLL;
      end
      CS_PLL: begin
        if (soft_rst_i)           nxt_o = CS_MAIN;
        else if (sync_pt_i) begin
          if (!want_fast_i)       nxt_o = CS_SUB;
          else if (want_direct_i) nxt_o = CS_MAIN;
        end
      end
      CS_SUB: begin
        if (soft_rst_i || want_fast_i) nxt_o = CS_WAIT;
      end
      CS_WAIT: begin
        if (!soft_rst_i && stab_done_i) begin
          if (!want_fast_i)       nxt_o = CS_SUB;
          else if (want_direct_i) nxt_o = CS_MAIN;
          else                    nxt_o = CS_PLL;
        end
      end
      default:                    nxt_o = CS_MAIN;
    endcase
  end

endmodule

// File: rtl/clksrc_status.sv
module clksrc_status
  import clksrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cs_state_e cur_i,
  input  cs_state_e nxt_i,
  output cs_stat_t  stat_o,
  output logic      chg_o,
  output logic      start_o
);

  cs_stat_t stat_nxt;
  assign stat_nxt = stat_of(nxt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o  <= STAT_MAIN;
      chg_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      stat_o  <= stat_nxt;
      chg_o   <= (stat_nxt != stat_o);
      start_o <= (nxt_i == CS_WAIT) && (cur_i != CS_WAIT);
    end
  end

endmodule

// File: rtl/clksrc_sel.sv
module clksrc_sel
  import clksrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic want_fast_i,
  input  logic want_direct_i,
  input  logic sub_edge_i,
  input  logic stab_done_i,
  input  logic sync_pt_i,
  output logic stat_hi_o,
  output logic stat_nopll_o,
  output logic stab_start_o,
  output logic stat_chg_o
);

  cs_state_e state_q, state_d;
  cs_stat_t  stat;

  clksrc_next u_next (
    .cur_i        (state_q),
    .soft_rst_i   (soft_rst_i),
    .want_fast_i  (want_fast_i),
    .want_direct_i(want_direct_i),
    .sub_edge_i   (sub_edge_i),
    .stab_done_i  (stab_done_i),
    .sync_pt_i    (sync_pt_i),
    .nxt_o        (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_MAIN;
    else        state_q <= state_d;
  end

  clksrc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (state_q),
    .nxt_i  (state_d),
    .stat_o (stat),
    .chg_o  (stat_chg_o),
    .start_o(stab_start_o)
  );

  assign stat_hi_o    = stat.hi;
  assign stat_nopll_o = stat.nopll;

endmodule

// File: rtl/clksrc_sel_chk.sv
module clksrc_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst_i,
  input logic sub_edge_i,
  input logic stab_done_i,
  input logic sync_pt_i,
  input logic stat_hi_o,
  input logic stat_nopll_o,
  input logic stab_start_o,
  input logic stat_chg_o
);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hi_o || stat_nopll_o));

  assert_start_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stab_start_o |-> (!stat_hi_o && stat_nopll_o));

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stab_start_o |=> !stab_start_o);

  assert_rise_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_hi_o) |-> $past(stab_done_i));

  assert_fall_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_hi_o) |-> $past(sub_edge_i || sync_pt_i));

  assert_pll_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_nopll_o) |-> $past(sync_pt_i || stab_done_i));

  assert_pll_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_nopll_o) |-> $past(sync_pt_i || soft_rst_i));

  assert_chg_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_chg_o == ({stat_hi_o, stat_nopll_o} != $past({stat_hi_o, stat_nopll_o})));

endmodule

bind clksrc_sel clksrc_sel_chk u_chk (.*);

// File: tb/clksrc_sel_bench.sv
`timescale 1ns/1ps
module clksrc_sel_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 1'b0, want_fast_i = 1'b1, want_direct_i = 1'b1;
  logic sub_edge_i = 1'b0, stab_done_i = 1'b0, sync_pt_i = 1'b0;
  logic stat_hi_o, stat_nopll_o, stab_start_o, stat_chg_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clksrc_sel u_clksrc_sel (.*);

  localparam logic [1:0] MAIN = 2'b11, PLL = 2'b10, SUB = 2'b01;

  task automatic chk(string req, logic [1:0] es, logic est, logic ec);
    logic [3:0] act, exp;
    act = {stat_hi_o, stat_nopll_o, stab_start_o, stat_chg_o};
    exp = {es, est, ec};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {stat,start,chg} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulse(ref logic s); s = 1'b1; step(); s = 1'b0; endtask

  task automatic t_reset();
    chk("R1", MAIN, 1'b0, 1'b0);
  endtask

  task automatic t_main_to_sub();
    want_fast_i = 1'b0;
    for (int i = 0; i < 3; i++) begin step(); chk("R2 lag", MAIN, 1'b0, 1'b0); end
    pulse(sync_pt_i);  chk("R7 sync on main", MAIN, 1'b0, 1'b0);
    pulse(sub_edge_i); chk("R2 edge", SUB, 1'b0, 1'b1);
    step();            chk("R10 drop", SUB, 1'b0, 1'b0);
  endtask

  task automatic t_sub_ignore();
    pulse(stab_done_i); chk("R7 done on sub", SUB, 1'b0, 1'b0);
    pulse(sync_pt_i);   chk("R7 sync on sub", SUB, 1'b0, 1'b0);
  endtask

  task automatic t_sub_to_pll();
    want_direct_i = 1'b0; want_fast_i = 1'b1;
    step(); chk("R3 start", SUB, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin step(); chk("R3 hold", SUB, 1'b0, 1'b0); end
    pulse(stab_done_i); chk("R4 to pll", PLL, 1'b0, 1'b1);
  endtask

  task automatic t_pll_main();
    want_direct_i = 1'b1;
    step(); step(); chk("R6 pll hold", PLL, 1'b0, 1'b0);
    pulse(sync_pt_i); chk("R6 to main", MAIN, 1'b0, 1'b1);
    want_direct_i = 1'b0;
    step(); chk("R6 main hold", MAIN, 1'b0, 1'b0);
    pulse(sync_pt_i); chk("R6 to pll", PLL, 1'b0, 1'b1);
  endtask

  task automatic t_pll_to_sub();
    want_fast_i = 1'b0; want_direct_i = 1'b1;
    pulse(sub_edge_i); chk("R5 edge ignored", PLL, 1'b0, 1'b0);
    pulse(sync_pt_i);  chk("R5 to sub", SUB, 1'b0, 1'b1);
    step();            chk("R5 settled", SUB, 1'b0, 1'b0);
  endtask

  task automatic t_wait_main();
    want_fast_i = 1'b1;
    step(); chk("R3 start", SUB, 1'b1, 1'b0);
    pulse(stab_done_i); chk("R4 to main", MAIN, 1'b0, 1'b1);
  endtask

  task automatic t_simul_main();
    want_fast_i = 1'b0; want_direct_i = 1'b0;
    pulse(sync_pt_i);  chk("R8 no pll", MAIN, 1'b0, 1'b0);
    pulse(sub_edge_i); chk("R8 to sub", SUB, 1'b0, 1'b1);
  endtask

  task automatic t_abandon();
    want_direct_i = 1'b1; want_fast_i = 1'b1;
    step(); chk("R3 start", SUB, 1'b1, 1'b0);
    want_fast_i = 1'b0;
    pulse(stab_done_i); chk("R11 back to sub", SUB, 1'b0, 1'b0);
    pulse(stab_done_i); chk("R11 done ignored", SUB, 1'b0, 1'b0);
    want_fast_i = 1'b1;
    step(); chk("R11 restart", SUB, 1'b1, 1'b0);
    pulse(stab_done_i); chk("R4 to main", MAIN, 1'b0, 1'b1);
  endtask

  task automatic t_softrst();
    want_fast_i = 1'b0;
    pulse(sub_edge_i);  chk("R2 edge", SUB, 1'b0, 1'b1);
    pulse(soft_rst_i);  chk("R9 sub to wait", SUB, 1'b1, 1'b0);
    want_fast_i = 1'b1; want_direct_i = 1'b0;
    pulse(stab_done_i); chk("R4 to pll", PLL, 1'b0, 1'b1);
    pulse(soft_rst_i);  chk("R9 pll to main", MAIN, 1'b0, 1'b1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_main_to_sub();
    t_sub_ignore();
    t_sub_to_pll();
    t_pll_main();
    t_pll_to_sub();
    t_wait_main();
    t_simul_main();
    t_abandon();
    t_softrst();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule